// File: doc/BRIEF.md
# Interrupt priority offset generator

This block picks the winning interrupt among a vector of pending sources and reports it as a byte offset. A handler adds that offset to the base of a jump table, so the offset is the source number multiplied by four. The order in which sources compete is not fixed. A table of 21 slots maps each slot to a source number, and a higher slot index means a higher priority. The winner is the highest slot whose mapped source is pending.

Each source also carries a class bit that places it in the fast class (bit set) or the normal class (bit clear). The block keeps three offsets, each held in a register and updated on every clock edge from the inputs sampled at that edge:

- one offset over all sources,
- one offset over fast-class sources only,
- one offset over normal-class sources only.

Software reads the three offsets through a small read port. When no source in a view qualifies, that view holds the "nothing pending" code 0x54, which is 21 × 4. No valid offset can take that value, so it is never confused with source 0, whose offset is 0x00. Pending-bit capture, masking, the bus fabric and processor-mode checks are handled outside this block.

Top module: `irq_offset_gen`

## Requirements
- R1: After reset, and until the first clock edge with reset released, all three views read 0x00000054.
- R2: Reading address 0x24 returns (winning source number) << 2, with bits 31:7 zero, over every pending source regardless of class.
- R3: A view in which no qualifying source is pending reads 0x00000054.
- R4: Among qualifying pending sources, the one mapped to the highest slot index wins; slot s maps to source `prio_map[5*s +: 5]`.
- R5: When source 0 wins (for example, source 0 alone pending under the identity map), the view reads 0x00000000.
- R6: Reading address 0x30 considers only sources whose `fiq_sel` bit is 1.
- R7: Reading address 0x34 considers only sources whose `fiq_sel` bit is 0.
- R8: A slot that maps to a source number of 21 or more never wins, even when other pending sources exist.
- R9: A cycle with `wr_en` high returns `rdata` = 0, and the write does not change any view; a later read shows the same values as without the write.
- R10: `rdata` is 0 when `rd_en` is low or when the address is not 0x24, 0x30 or 0x34.
- R11: A change on `pend`, `fiq_sel` or `prio_map` shows in the views only after the next rising clock edge. Before that edge the read value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend | input | 21 | Pending bit per source |
| fiq_sel | input | 21 | Class bit per source: 1 = fast, 0 = normal |
| prio_map | input | 105 | Slot-to-source table, 5 bits per slot; slot 20 has the highest priority |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe; the block takes no write data |
| addr | input | 8 | Register byte offset |
| rdata | output | 32 | Read data, combinational from the held views |

## Verification
The hardest case to reach from the ports is a view in which the pending sources are all in the other class or mapped only through out-of-range slots. In that case the view must still read the empty code even though `pend` is non-zero. The random stimulus draws sparse pending vectors, random class bits and slot tables that are either a shuffled permutation or contain invalid entries. It also includes directed cases for source 0 winning, all-invalid tables, and a single source flipping between the two classes. Every view is compared against a bench model that scans the slot table directly.

// File: rtl/irq_ofs_pkg.sv
package irq_ofs_pkg;

    localparam int NUM_SRC_D = 21;
    localparam int SRC_W_D   = 5;
    localparam int DATA_W_D  = 32;
    localparam int ADDR_W_D  = 8;

    localparam logic [7:0] ADDR_ALL = 8'h24;
    localparam logic [7:0] ADDR_FIQ = 8'h30;
    localparam logic [7:0] ADDR_IRQ = 8'h34;

    typedef enum logic [1:0] {
        VIEW_ALL  = 2'd0,
        VIEW_FIQ  = 2'd1,
        VIEW_IRQ  = 2'd2,
        VIEW_NONE = 2'd3
    } view_e;

    localparam int NUM_VIEWS = 3;

endpackage

// File: rtl/prio_slot_resolver.sv
module prio_slot_resolver #(
    parameter int NUM_SRC = 21,
    parameter int SRC_W   = 5
) (
    input  logic [NUM_SRC-1:0]       pend_m,
    input  logic [NUM_SRC*SRC_W-1:0] map_flat,
    output logic                     found,
    output logic [SRC_W-1:0]         win_src
);

    logic [NUM_SRC-1:0] slot_hit;

    // R8: a slot whose entry is out of range is treated as empty
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            logic [SRC_W-1:0] m;
            m = map_flat[s*SRC_W +: SRC_W];
            slot_hit[s] = 1'b0;
            if (int'(m) < NUM_SRC) begin
                slot_hit[s] = pend_m[m];
            end
        end
    end

    // R4: scan upward so the last hit seen (highest slot) wins
    always_comb begin
        found   = 1'b0;
        win_src = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (slot_hit[s]) begin
                found   = 1'b1;
                win_src = map_flat[s*SRC_W +: SRC_W];
            end
        end
    end

    always_comb begin
        if (found) begin
            a_r8_win_in_range: assert (int'(win_src) < NUM_SRC)
                else $error("winner out of range");
        end
    end

endmodule

// File: rtl/offset_view_reg.sv
module offset_view_reg #(
    parameter int NUM_SRC = 21,
    parameter int SRC_W   = 5,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              found,
    input  logic [SRC_W-1:0]  win_src,
    output logic [DATA_W-1:0] ofs_q
);

    localparam logic [DATA_W-1:0] EMPTY_CODE = DATA_W'(NUM_SRC) << 2;

    logic [DATA_W-1:0] ofs_d;

    always_comb begin
        ofs_d = found ? (DATA_W'(win_src) << 2) : EMPTY_CODE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= EMPTY_CODE;
        end else begin
            ofs_q <= ofs_d;
        end
    end

    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_q[1:0] == 2'b00);

    a_r3_empty_or_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_q == EMPTY_CODE) || (ofs_q < EMPTY_CODE));

endmodule

// File: rtl/reg_read_port.sv
module reg_read_port
    import irq_ofs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] view_all,
    input  logic [DATA_W-1:0] view_fiq,
    input  logic [DATA_W-1:0] view_irq,
    output logic [DATA_W-1:0] rdata
);

    view_e sel;

    always_comb begin
        if (addr == ADDR_W'(ADDR_ALL))      sel = VIEW_ALL;
        else if (addr == ADDR_W'(ADDR_FIQ)) sel = VIEW_FIQ;
        else if (addr == ADDR_W'(ADDR_IRQ)) sel = VIEW_IRQ;
        else                                sel = VIEW_NONE;
    end

    // R9, R10: writes and idle or unmapped accesses return zero
    always_comb begin
        rdata = '0;
        if (rd_en && !wr_en) begin
            unique case (sel)
                VIEW_ALL:  rdata = view_all;
                VIEW_FIQ:  rdata = view_fiq;
                VIEW_IRQ:  rdata = view_irq;
                VIEW_NONE: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_offset_gen.sv
module irq_offset_gen
    import irq_ofs_pkg::*;
#(
    parameter int NUM_SRC = NUM_SRC_D,
    parameter int SRC_W   = SRC_W_D,
    parameter int DATA_W  = DATA_W_D,
    parameter int ADDR_W  = ADDR_W_D
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       pend,
    input  logic [NUM_SRC-1:0]       fiq_sel,
    input  logic [NUM_SRC*SRC_W-1:0] prio_map,
    input  logic                     rd_en,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    output logic [DATA_W-1:0]        rdata
);

    localparam logic [DATA_W-1:0] EMPTY_CODE = DATA_W'(NUM_SRC) << 2;

    logic [NUM_SRC-1:0] cls_pend [NUM_VIEWS];
    logic               cls_found [NUM_VIEWS];
    logic [SRC_W-1:0]   cls_src [NUM_VIEWS];
    logic [DATA_W-1:0]  view_q [NUM_VIEWS];

    for (genvar g = 0; g < NUM_VIEWS; g++) begin : g_view
        if (g == int'(VIEW_ALL)) begin : g_all
            assign cls_pend[g] = pend;
        end else if (g == int'(VIEW_FIQ)) begin : g_fiq
            assign cls_pend[g] = pend & fiq_sel;   // R6
        end else begin : g_irq
            assign cls_pend[g] = pend & ~fiq_sel;  // R7
        end

        prio_slot_resolver #(
            .NUM_SRC (NUM_SRC),
            .SRC_W   (SRC_W)
        ) res_i (
            .pend_m   (cls_pend[g]),
            .map_flat (prio_map),
            .found    (cls_found[g]),
            .win_src  (cls_src[g])
        );

        offset_view_reg #(
            .NUM_SRC (NUM_SRC),
            .SRC_W   (SRC_W),
            .DATA_W  (DATA_W)
        ) vreg_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .found   (cls_found[g]),
            .win_src (cls_src[g]),
            .ofs_q   (view_q[g])
        );
    end

    reg_read_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) rport_i (
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .addr     (addr),
        .view_all (view_q[0]),
        .view_fiq (view_q[1]),
        .view_irq (view_q[2]),
        .rdata    (rdata)
    );

    a_r3_empty_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend) == '0) |-> (view_q[0] == EMPTY_CODE));

    a_r6_fiq_winner_class: assert property (@(posedge clk) disable iff (!rst_n)
        (view_q[1] != EMPTY_CODE) |->
        |($past(pend & fiq_sel) & (NUM_SRC'(1) << view_q[1][SRC_W+1:2])));

    a_r7_irq_winner_class: assert property (@(posedge clk) disable iff (!rst_n)
        (view_q[2] != EMPTY_CODE) |->
        |($past(pend & ~fiq_sel) & (NUM_SRC'(1) << view_q[2][SRC_W+1:2])));

    a_r10_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));

    a_r9_write_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rdata == '0));

endmodule

// File: tb/irq_offset_gen_tb.sv
module irq_offset_gen_tb_top;

    localparam int N  = 21;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pend = '0;
    logic [N-1:0]  fiq_sel = '0;
    logic [N*SW-1:0] prio_map = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   rdata;

    int total = 0;
    int bad = 0;
    int map_a [N];

    always #5 clk = ~clk;

    irq_offset_gen dut_i (
        .clk(clk), .rst_n(rst_n), .pend(pend), .fiq_sel(fiq_sel),
        .prio_map(prio_map), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .rdata(rdata)
    );

    function automatic logic [N*SW-1:0] pack_map();
        logic [N*SW-1:0] v;
        v = '0;
        for (int s = 0; s < N; s++) v[s*SW +: SW] = SW'(map_a[s]);
        return v;
    endfunction

    // mode 0: all, 1: fast class, 2: normal class
    function automatic logic [31:0] model(logic [N-1:0] p, logic [N-1:0] f, int mode);
        logic [31:0] r;
        r = 32'h54;
        for (int s = 0; s < N; s++) begin
            int m;
            m = map_a[s];
            if (m < N && p[m] &&
                (mode == 0 || (mode == 1 && f[m]) || (mode == 2 && !f[m])))
                r = 32'(m) << 2;
        end
        return r;
    endfunction

    task automatic check(logic [31:0] act, logic [31:0] exp, string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        #1;
        check(rdata, exp, req);
        rd_en = 1'b0;
    endtask

    task automatic apply(logic [N-1:0] p, logic [N-1:0] f);
        @(negedge clk);
        pend = p; fiq_sel = f; prio_map = pack_map();
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(string req);
        rd(8'h24, model(pend, fiq_sel, 0), {req, " all R2"});
        rd(8'h30, model(pend, fiq_sel, 1), {req, " fast R6"});
        rd(8'h34, model(pend, fiq_sel, 2), {req, " normal R7"});
    endtask

    task automatic identity_map();
        for (int s = 0; s < N; s++) map_a[s] = s;
    endtask

    task automatic shuffle_map();
        identity_map();
        for (int i = N - 1; i > 0; i--) begin
            int j, t;
            j = int'($urandom % (i + 1));
            t = map_a[i]; map_a[i] = map_a[j]; map_a[j] = t;
        end
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4519));
        identity_map();
        prio_map = pack_map();
        #23;
        // R1: reset values
        rd(8'h24, 32'h54, "R1 all");
        rd(8'h30, 32'h54, "R1 fast");
        rd(8'h34, 32'h54, "R1 normal");
        @(negedge clk);
        rst_n = 1'b1;

        // R3: nothing pending
        apply('0, '0);
        check_all("R3 empty");

        // R5: source 0 alone, identity map
        apply(21'h1, '0);
        rd(8'h24, 32'h0, "R5 src0 all");
        rd(8'h34, 32'h0, "R5 src0 normal");
        rd(8'h30, 32'h54, "R5 src0 fast empty R3");

        // R4: identity map, top source wins
        apply(21'h100005, 21'h000004);
        rd(8'h24, 32'd20 << 2, "R4 highest slot");
        rd(8'h30, 32'd2 << 2, "R4 fast");
        rd(8'h34, 32'd20 << 2, "R4 normal");

        // R4: reversed map, source 0 now highest priority
        for (int s = 0; s < N; s++) map_a[s] = N - 1 - s;
        apply(21'h100001, '0);
        rd(8'h24, 32'h0, "R4 reversed map R5");

        // R8: invalid entries never win
        for (int s = 0; s < N; s++) map_a[s] = 31;
        apply('1, '0);
        rd(8'h24, 32'h54, "R8 all slots invalid");
        map_a[3] = 7;
        apply('1, '0);
        rd(8'h24, 32'd7 << 2, "R8 one valid slot");

        // class flip of a single source
        identity_map();
        apply(21'h000200, 21'h000200);
        rd(8'h30, 32'd9 << 2, "R6 source in fast class");
        rd(8'h34, 32'h54, "R7 source not in normal class");
        apply(21'h000200, 21'h000000);
        rd(8'h30, 32'h54, "R6 source moved out");
        rd(8'h34, 32'd9 << 2, "R7 source moved in");

        // R11: new inputs are not visible before the edge
        @(negedge clk);
        pend = 21'h000010;
        rd(8'h24, 32'd9 << 2, "R11 before edge");
        @(posedge clk); #1;
        rd(8'h24, 32'd4 << 2, "R11 after edge");

        // R9: write returns zero and leaves views intact
        addr = 8'h24; rd_en = 1'b1; wr_en = 1'b1;
        #1;
        check(rdata, 32'h0, "R9 write cycle");
        wr_en = 1'b0;
        #1;
        check(rdata, 32'd4 << 2, "R9 view intact");
        rd_en = 1'b0;

        // R10: idle and unmapped
        addr = 8'h24; #1;
        check(rdata, 32'h0, "R10 rd_en low");
        rd(8'h28, 32'h0, "R10 unmapped 0x28");
        rd(8'h00, 32'h0, "R10 unmapped 0x00");

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [N-1:0] p, f;
            shuffle_map();
            if (it % 5 == 0) map_a[$urandom % N] = 21 + int'($urandom % 11);
            p = N'($urandom);
            if (it % 3 == 0) p = p & N'($urandom) & N'($urandom);
            f = N'($urandom);
            apply(p, f);
            check_all("R4 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule